// File: doc/BRIEF.md
# Hysteretic Brightness Code Quantizer

This block turns a digitized control sample into a steady 5-bit brightness code. The code is measured against a digitized full-scale reference. A raw code is formed by scaling the sample to 32 levels of the reference. A one-step dead band then stops the held code from toggling when noise keeps the sample near a level boundary. A polarity input picks the scale direction. In positive scale the code climbs as the sample rises. In negative scale the same span runs from 31 down to 0.

A sample is taken only on a clock where the valid strobe is high. The first valid sample after reset loads the raw code directly. Later samples move the held code only when the raw code has left the dead band, and the move stops one step short of the raw code. Each change of the output code is marked by a one-clock pulse.

Top module: `bright_code_quant`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released with negative scale low, `code_out` is 0 and `code_changed` is 0.
- R2: The raw code is floor(32*sample/reference), limited to 31. A sample equal to or above the reference gives 31, and a reference of 0 gives 0. The first valid sample after reset loads the raw code into the held code with no dead band. The result is visible from the clock edge that samples the strobe.
- R3: `code_out` equals the held code when `neg_scale` is 0, and 31 minus the held code when `neg_scale` is 1. It follows `neg_scale` as sampled at the previous clock edge. The dead band acts on the held code before the inversion.
- R4: Once loaded, the held code rises only when the raw code is at least 2 above it, and it then becomes the raw code minus 1.
- R5: Once loaded, the held code falls only when the raw code is at least 2 below it, and it then becomes the raw code plus 1. A raw code within one step of the held code leaves it unchanged.
- R6: On a clock where `sample_valid` is 0, the held code does not change, whatever the sample and reference inputs are.
- R7: `code_changed` is 1 for exactly the clock in which `code_out` holds a value that differs from its value in the clock before. This includes changes caused only by `neg_scale`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| neg_scale | input | 1 | 1 selects negative scale (code falls as the sample rises) |
| sample_valid | input | 1 | Strobe: the sample and reference are taken on this clock |
| sample | input | 10 | Digitized control sample |
| reference | input | 10 | Digitized full-scale reference |
| code_out | output | 5 | Brightness code, registered |
| code_changed | output | 1 | One-clock pulse when the code changes |

## Verification
A wrong held code shows up on `code_out` on the clock right after the strobe that caused it. It is then seen in both polarities, because the inversion is applied after the held code. A dead band that is off by one, or a move that lands on the raw code instead of one step short, is caught by strobes with raw codes exactly one and exactly two steps from the held value. Errors in the loaded flag, or in the path that holds the code while the strobe is low, only become visible on the next strobe. The bench therefore follows every ignored stimulus with a strobe whose outcome depends on the held value.

// File: rtl/bright_code_quant.sv
module bright_code_quant #(
  parameter int SAMPLE_W = 10,
  parameter int CODE_W   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                neg_scale,
  input  logic                sample_valid,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [SAMPLE_W-1:0] reference,
  output logic [CODE_W-1:0]   code_out,
  output logic                code_changed
);
  localparam int LEVELS   = 1 << CODE_W;
  localparam int PROD_W   = SAMPLE_W + CODE_W + 1;
  localparam int CODE_MAX = LEVELS - 1;

  logic [PROD_W-1:0]   scaled_s;
  logic [CODE_MAX-1:0] above;
  logic [CODE_W-1:0]   raw_code, held, held_nx, out_nx;
  logic                loaded;

  assign scaled_s = PROD_W'(sample) << CODE_W;

  for (genvar k = 1; k <= CODE_MAX; k++) begin : g_thr
    assign above[k-1] = scaled_s >= (PROD_W'(k) * PROD_W'(reference));
  end

  always_comb begin
    raw_code = '0;
    if (reference != '0)
      for (int i = 0; i < CODE_MAX; i++)
        raw_code = raw_code + CODE_W'(above[i]);
  end

  logic [CODE_W:0] raw_x, held_x;
  assign raw_x  = {1'b0, raw_code};
  assign held_x = {1'b0, held};

  always_comb begin
    held_nx = held;
    if (sample_valid) begin
      if (!loaded)                 held_nx = raw_code;
      else if (raw_x >= held_x + 2) held_nx = raw_code - 1'b1;
      else if (raw_x + 2 <= held_x) held_nx = raw_code + 1'b1;
    end
  end

  assign out_nx = neg_scale ? CODE_W'(CODE_MAX) - held_nx : held_nx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held         <= '0;
      loaded       <= 1'b0;
      code_out     <= '0;
      code_changed <= 1'b0;
    end else begin
      held         <= held_nx;
      loaded       <= loaded | sample_valid;
      code_out     <= out_nx;
      code_changed <= out_nx != code_out;
    end
  end
endmodule

// File: rtl/bright_code_quant_chk.sv
module bright_code_quant_chk #(
  parameter int CODE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              neg_scale,
  input logic              sample_valid,
  input logic              loaded,
  input logic [CODE_W-1:0] raw_code,
  input logic [CODE_W-1:0] held,
  input logic [CODE_W-1:0] code_out,
  input logic              code_changed
);
  localparam logic [CODE_W-1:0] TOP = '1;

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> $stable(held));

  // R4
  rise_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && sample_valid && ({1'b0, raw_code} >= {1'b0, held} + 2))
      |=> held == $past(raw_code) - 1'b1);

  // R5
  fall_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && sample_valid && ({1'b0, raw_code} + 2 <= {1'b0, held}))
      |=> held == $past(raw_code) + 1'b1);

  // R3
  polarity_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> code_out == ($past(neg_scale) ? TOP - held : held));

  // R7
  change_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_changed |-> code_out != $past(code_out));
endmodule

bind bright_code_quant bright_code_quant_chk #(.CODE_W(CODE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .neg_scale(neg_scale), .sample_valid(sample_valid),
  .loaded(loaded), .raw_code(raw_code), .held(held),
  .code_out(code_out), .code_changed(code_changed)
);

// File: tb/bright_code_quant_tb_top.sv
module bright_code_quant_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       neg_scale = 1'b0;
  logic       sample_valid = 1'b0;
  logic [9:0] sample = '0;
  logic [9:0] reference = '0;
  logic [4:0] code_out;
  logic       code_changed;

  int n_run = 0;
  int n_fail = 0;

  int m_held = 0;
  bit m_loaded = 0;
  int m_out = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bright_code_quant dut_i (
    .clk(clk), .rst_n(rst_n), .neg_scale(neg_scale), .sample_valid(sample_valid),
    .sample(sample), .reference(reference),
    .code_out(code_out), .code_changed(code_changed)
  );

  function automatic int raw_of(int s, int r);
    if (r == 0) return 0;
    if (s >= r) return 31;
    return (32 * s) / r;
  endfunction

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sample_valid = 1'b0; neg_scale = 1'b0;
    @(posedge clk); #1;
    check("R1 code_out in reset", code_out, 0);
    check("R1 code_changed in reset", code_changed, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 code_out after reset", code_out, 0);
    check("R1 code_changed after reset", code_changed, 0);
    m_held = 0; m_loaded = 0; m_out = 0;
  endtask

  task automatic step(string req, bit v, int s, int r, bit neg);
    int raw, nout;
    @(negedge clk);
    sample_valid = v; sample = 10'(s); reference = 10'(r); neg_scale = neg;
    raw = raw_of(s, r);
    if (v) begin
      if (!m_loaded)              m_held = raw;
      else if (raw >= m_held + 2) m_held = raw - 1;
      else if (raw + 2 <= m_held) m_held = raw + 1;
      m_loaded = 1;
    end
    nout = neg ? 31 - m_held : m_held;
    @(posedge clk); #1;
    sample_valid = 1'b0;
    check({req, " code"}, code_out, nout);
    check({req, " pulse"}, code_changed, int'(nout != m_out));
    m_out = nout;
  endtask

  task automatic t_first_load();
    do_reset();
    step("R2 first load direct", 1, 100, 800, 0);
    check("R2 first load value", code_out, 4);
    step("R7 no change no pulse", 0, 0, 0, 0);
  endtask

  task automatic t_band_up_down();
    step("R2 load mid", 1, 400, 800, 0);
    step("R5 raw +1 ignored", 1, 425, 800, 0);
    check("R5 held still 16", code_out, 16);
    step("R4 raw +2 moves to raw-1", 1, 450, 800, 0);
    check("R4 value 17", code_out, 17);
    step("R5 raw -1 ignored", 1, 400, 800, 0);
    step("R5 raw -2 moves to raw+1", 1, 375, 800, 0);
    check("R5 value 16", code_out, 16);
  endtask

  task automatic t_ignore();
    step("R6 strobe low big sample", 0, 800, 800, 0);
    step("R6 strobe low zero ref", 0, 5, 0, 0);
    step("R6 held probe raw+1", 1, 425, 800, 0);
    check("R6 held unchanged", code_out, 16);
  endtask

  task automatic t_clamp_zero();
    step("R2 sample above reference", 1, 900, 800, 0);
    check("R2 clamp gives 30", code_out, 30);
    step("R2 zero reference", 1, 300, 0, 0);
    check("R2 zero ref to 1", code_out, 1);
    step("R2 exact reference", 1, 1023, 1023, 0);
    check("R2 exact ref 30", code_out, 30);
  endtask

  task automatic t_negative();
    step("R3 polarity flip only", 0, 0, 0, 1);
    check("R3 inverted 1", code_out, 1);
    step("R3 neg raw 0", 1, 0, 800, 1);
    check("R3 neg after fall", code_out, 30);
    step("R3 neg raw +1 ignored", 1, 50, 800, 1);
    step("R3 neg full", 1, 800, 800, 1);
    check("R3 neg full gives 1", code_out, 1);
    step("R7 flip back", 0, 0, 0, 0);
    check("R7 flip back value", code_out, 30);
  endtask

  task automatic t_sweep();
    do_reset();
    for (int s = 0; s <= 1000; s += 37) step("R4 sweep up", 1, s, 1000, 0);
    for (int s = 1000; s >= 0; s -= 41) step("R5 sweep down", 1, s, 1000, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_first_load();
    t_band_up_down();
    t_ignore();
    t_clamp_zero();
    t_negative();
    t_sweep();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule